// File: doc/BRIEF.md
# Multi-Digit Seven-Segment Decoder with Leading-Zero Suppression

This block turns a row of binary-coded decimal digits into segment patterns for a common-cathode seven-segment display, where a segment lights when its output bit is 1. Each digit has its own decoder slice. The slices are chained from the most significant digit down by a suppression signal. The signal runs through each leading zero, and that zero is shown dark. The first digit that is not zero breaks the chain, so any zero after it, whether inside the number or at the end, is drawn normally. The least significant digit is always shown, so a value of zero appears as a single `0` and not as an empty display.

Two controls are shared by all digits. Lamp-test lights every segment of every digit so that a missing segment can be spotted. Blank turns the whole display dark. Codes 10 to 15 are not decimal digits: they show as a dark digit, and they end the suppression chain. The segment bus is registered, and a synchronous active-high reset clears it.

Top module: `seg_chain`

## Requirements
- R1: With lamp-test and blank both low, a shown digit whose code is 0 to 9 drives its 7-bit field with bit 0 = segment a through bit 6 = segment g. The patterns in hex are 0→3F, 1→06, 2→5B, 3→4F, 4→66, 5→6D, 6→7D, 7→07, 8→7F and 9→6F.
- R2: A digit code of 10 to 15 gives an all-dark field (00). It counts as a nonzero digit, so it ends leading-zero suppression for every lower digit.
- R3: When lamp-test is high, every field is 7F. This holds whatever the digit codes, the blank input and the suppression state are.
- R4: When lamp-test is low and blank is high, every field is 00.
- R5: Leading zeros are dark. Digit NDIG-1, the most significant, starts the suppression chain. Each zero digit is dark while every digit above it is also zero.
- R6: When any higher digit is nonzero, a zero digit shows the pattern 3F. This covers zeros inside the number and zeros at the end.
- R7: Digit 0 is never suppressed. When all digits are zero, only digit 0 shows 3F.
- R8: The output is registered. `seg_o` reflects the inputs sampled at the previous rising clock edge. A synchronous high `rst` forces `seg_o` to all zeros on the next edge, even while lamp-test is high.
- R9: Digit i occupies `digit_i[4*i+3:4*i]` and `seg_o[7*i+6:7*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| digit_i | input | 4*NDIG | BCD digits, digit 0 least significant in bits 3:0 |
| lamp_test_i | input | 1 | Light all segments of all digits |
| blank_i | input | 1 | Darken all digits (below lamp-test in priority) |
| seg_o | output | 7*NDIG | Registered active-high segments, 7 bits per digit |

## Verification
Three kinds of stimulus are used, each aimed at a different part of the design.

- **Decimal sweep.** A strided run over the five-digit decimal values covers every count of leading zeros. It separates leading zeros from zeros inside the number and zeros at the end.
- **Scrambled codes.** Hashed 20-bit words put codes 10 to 15 at every position. They show whether an invalid code ends suppression or lets it pass through.
- **Control sweeps.** Every digit code is tried under each lamp-test and blank combination, both at the top position and at the bottom position. These sweeps show the control priority and that the least significant digit is always shown.

Fixed words such as all zeros and 00011 fix the single-`0` and partial-suppression cases.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef logic [6:0] seg_t;

  localparam seg_t SEG_ALL = 7'h7F;
  localparam seg_t SEG_OFF = 7'h00;

  // bit 0 = segment a ... bit 6 = segment g, 1 = lit
  function automatic seg_t bcd_to_seg(input logic [3:0] code);
    seg_t s;
    case (code)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = SEG_OFF; // R2: non-decimal codes are dark
    endcase
    return s;
  endfunction
endpackage

// File: rtl/seg_slice.sv
module seg_slice
  import seg_pkg::*;
(
  input  logic [3:0] bcd_i,
  input  logic       lamp_i,
  input  logic       blank_i,
  input  logic       sup_in_i,
  output seg_t       seg_o,
  output logic       sup_out_o
);
  logic is_zero;
  logic hide;

  assign is_zero = (bcd_i == 4'd0);
  // a leading zero stays dark and passes suppression down (R5)
  assign hide      = sup_in_i & is_zero;
  assign sup_out_o = hide;

  always_comb begin
    if (lamp_i)                // R3: highest priority
      seg_o = SEG_ALL;
    else if (blank_i || hide)  // R4, R5
      seg_o = SEG_OFF;
    else
      seg_o = bcd_to_seg(bcd_i);
  end
endmodule

// File: rtl/seg_outreg.sv
module seg_outreg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/seg_chain.sv
module seg_chain
  import seg_pkg::*;
#(
  parameter int NDIG = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4*NDIG-1:0] digit_i,
  input  logic              lamp_test_i,
  input  logic              blank_i,
  output logic [7*NDIG-1:0] seg_o
);
  localparam int DW  = 4 * NDIG;
  localparam int SW  = 7 * NDIG;
  localparam int MSD = NDIG - 1;

  logic [NDIG-1:0] sup_in;
  logic [NDIG-1:0] sup_out;
  logic [SW-1:0]   seg_next;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    if (i == 0) begin : g_lsd
      assign sup_in[i] = 1'b0;           // R7: lowest digit always shown
    end else if (i == MSD) begin : g_msd
      assign sup_in[i] = 1'b1;           // R5: chain starts suppressed
    end else begin : g_mid
      assign sup_in[i] = sup_out[i+1];
    end

    seg_slice u_slice (
      .bcd_i     (digit_i[4*i +: 4]),
      .lamp_i    (lamp_test_i),
      .blank_i   (blank_i),
      .sup_in_i  (sup_in[i]),
      .seg_o     (seg_next[7*i +: 7]),
      .sup_out_o (sup_out[i])
    );
  end

  seg_outreg #(.W(SW)) u_oreg (
    .clk (clk),
    .rst (rst),
    .d_i (seg_next),
    .q_o (seg_o)
  );

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (seg_o == '0)); // R8

  AST_LAMP_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    lamp_test_i |=> (seg_o == {SW{1'b1}})); // R3

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
    (!lamp_test_i && blank_i) |=> (seg_o == '0)); // R4

  AST_LSD_LIT: assert property (@(posedge clk) disable iff (rst)
    (!lamp_test_i && !blank_i && digit_i[3:0] < 4'd10) |=> (seg_o[6:0] != 7'h00)); // R7

  if (NDIG > 1) begin : g_msd_chk
    AST_MSD_ZERO_DARK: assert property (@(posedge clk) disable iff (rst)
      (!lamp_test_i && digit_i[DW-1 -: 4] == 4'd0) |=> (seg_o[SW-1 -: 7] == 7'h00)); // R5
  end
endmodule

// File: tb/sim_seg_chain.sv
module sim_seg_chain;
  localparam int CLK_PERIOD = 10;
  localparam int NDIG = 5;
  localparam int DW = 4 * NDIG;
  localparam int SW = 7 * NDIG;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] digit_i = '0;
  logic          lamp_test_i = 1'b0;
  logic          blank_i = 1'b0;
  logic [SW-1:0] seg_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  seg_chain #(.NDIG(NDIG)) u0 (
    .clk(clk), .rst(rst), .digit_i(digit_i),
    .lamp_test_i(lamp_test_i), .blank_i(blank_i), .seg_o(seg_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] pat(input logic [3:0] c);
    case (c)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  function automatic logic [SW-1:0] model(input logic [DW-1:0] d, input logic lt, input logic bl);
    logic [SW-1:0] r;
    logic sup;
    r = '0;
    sup = 1'b1;
    for (int i = NDIG - 1; i >= 0; i--) begin
      logic [3:0] c;
      c = d[4*i +: 4];
      if (i == 0) sup = 1'b0;
      if (lt)                   r[7*i +: 7] = 7'h7F;
      else if (bl)              r[7*i +: 7] = 7'h00;
      else if (sup && c == 0)   r[7*i +: 7] = 7'h00;
      else                      r[7*i +: 7] = pat(c);
      if (c != 0) sup = 1'b0;
    end
    return r;
  endfunction

  // drive at negedge, the register loads at posedge, check at next negedge
  task automatic apply(input logic [DW-1:0] d, input logic lt, input logic bl, input string req);
    digit_i = d; lamp_test_i = lt; blank_i = bl;
    @(negedge clk);
    n_checks++;
    if (seg_o !== model(d, lt, bl)) begin
      n_fail++;
      $display("FAIL %s: digits=%h lt=%0b bl=%0b actual=%h expected=%h",
               req, d, lt, bl, seg_o, model(d, lt, bl));
    end
  endtask

  function automatic logic [DW-1:0] to_bcd(input int v);
    logic [DW-1:0] r;
    int x;
    x = v;
    r = '0;
    for (int i = 0; i < NDIG; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
      $finish;
    end
  end

  initial begin
    // R8: reset clears output even with lamp-test high
    digit_i = 20'h12345; lamp_test_i = 1'b1; rst = 1'b1;
    @(negedge clk); @(negedge clk);
    n_checks++;
    if (seg_o !== '0) begin
      n_fail++;
      $display("FAIL R8: reset actual=%h expected=0", seg_o);
    end
    rst = 1'b0;
    lamp_test_i = 1'b0;

    apply(20'h00000, 1'b0, 1'b0, "R7");
    apply(20'h00011, 1'b0, 1'b0, "R5");
    apply(20'h10000, 1'b0, 1'b0, "R6");
    apply(20'h00102, 1'b0, 1'b0, "R6");
    apply(20'h0A000, 1'b0, 1'b0, "R2");
    apply(20'h98765, 1'b0, 1'b0, "R9");
    apply(20'h43210, 1'b0, 1'b0, "R1");

    // R8: one-cycle latency, output follows the previous sample only
    apply(20'h00005, 1'b0, 1'b0, "R8");
    apply(20'h00050, 1'b0, 1'b0, "R8");

    // control sweeps: every code at bottom and top, each control combo
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 4; k++) begin
        apply(DW'(c), k[1], k[0], "R1_R3_R4_R7");
        apply(DW'(c) << (4*(NDIG-1)), k[1], k[0], "R2_R3_R4_R5");
      end
    end

    // decimal sweep: leading, embedded and trailing zeros
    for (int v = 0; v < 100000; v += 7) apply(to_bcd(v), 1'b0, 1'b0, "R5_R6");

    // scrambled hex words: invalid codes everywhere
    for (int i = 0; i < 20000; i++) begin
      logic [31:0] h;
      h = i * 32'd40503 + 32'd977;
      apply(h[DW-1:0], 1'b0, (i % 29) == 0, "R2_R6");
    end

    // lamp-test overrides suppression and blank (R3)
    apply(20'h00000, 1'b1, 1'b1, "R3");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule